// File: doc/BRIEF.md
# Boot Source Selector with Blank-Flash Check

This block decides which memory is aliased at address zero once reset ends. It combines a boot pin with three option bits: a software boot value, a bit that chooses between the pin and the software value, and an active-low secondary boot bit. It also looks at the first word of main flash. From these it chooses main flash, system memory or SRAM. The choice is captured once when reset is released. It is taken again from the current inputs when a standby-exit pulse arrives. A blank first flash word makes the block boot system memory instead of main flash, but only when the pin is what decides the boot.

The block keeps an `emptyFlag` that software can see and can write. The flag is loaded only during the option-load step that follows reset. A software remap value then drives the address-zero alias. It starts out equal to the boot decision. Software can later point the alias at any of the three boot memories or at an external flash bank. Software writes are accepted only when the selector is idle, which `bootValid` shows.

Source encoding used on `bootSel`, `aliasSel` and `remapWrVal`: 0 = main flash, 1 = system memory, 2 = SRAM, 3 = external flash. `aliasOneHot` has bit k set when `aliasSel` equals k.

Top module: `boot_alias_select`

## Requirements
- R1: The effective boot bit is `bootPin` when `optPinSel` is 1, and the inverse of `optSwBoot` when `optPinSel` is 0.
- R2: When the effective boot bit is 0 and the flash-blank rule (R4) does not apply, `bootSel` is 0 (main flash).
- R3: When the effective boot bit is 1, `bootSel` is 2 (SRAM) if `optSecBootN` is 0 and 1 (system memory) if it is 1. `bootSel` never takes the value 3.
- R4: When `optPinSel` is 1, `bootPin` is 0 and flash counts as empty, `bootSel` is 1 (system memory). When `optPinSel` is 0, a blank flash has no effect and `optSwBoot`=1 gives main flash.
- R5: At the option load after reset, `emptyFlag` becomes 1 if `flashWord0` is all ones and 0 otherwise. Later changes of `flashWord0` leave the flag unchanged.
- R6: A pulse on `emptyWrEn` while `bootValid` is 1 loads `emptyWrVal` into `emptyFlag` on the next edge. The stored flag is the one the standby resample uses.
- R7: The boot inputs are captured on the first clock edge after `rstN` rises. Later input changes do not alter `bootSel` until a standby exit.
- R8: A one-cycle `standbyExit` pulse while `bootValid` is 1 makes the block resample the boot inputs two edges later. The resample uses the stored `emptyFlag`. Both `bootSel` and `aliasSel` take the new decision.
- R9: `aliasSel` equals `bootSel` after every capture. A `remapWrEn` pulse while `bootValid` is 1 loads `remapWrVal` (including 3, external flash) into `aliasSel` without changing `bootSel`. `aliasOneHot` is the one-hot form of `aliasSel`.
- R10: During reset, `bootSel`, `aliasSel` and `emptyFlag` are 0 and `bootValid` is 0. `bootValid` is also 0 during the cycle in which a resample is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bootPin | input | 1 | Boot pin level |
| optPinSel | input | 1 | 1: pin decides the boot bit; 0: software option decides |
| optSwBoot | input | 1 | Software boot option, inverted to form the boot bit |
| optSecBootN | input | 1 | Secondary boot option, active low (0 selects SRAM) |
| flashWord0 | input | FLASH_W | First word of main flash |
| standbyExit | input | 1 | One-cycle pulse on standby exit |
| emptyWrEn | input | 1 | Software write strobe for the empty flag |
| emptyWrVal | input | 1 | Value written to the empty flag |
| remapWrEn | input | 1 | Software write strobe for the alias selection |
| remapWrVal | input | 2 | Alias source to write |
| bootSel | output | 2 | Captured boot source |
| aliasSel | output | 2 | Source aliased at address zero |
| aliasOneHot | output | 4 | One-hot form of aliasSel |
| emptyFlag | output | 1 | Flash-blank flag |
| bootValid | output | 1 | Selection settled, software writes accepted |

## Verification
A wrong captured decision shows on `bootSel` and `aliasSel` at the first sampling point after the capture edge. That is half a cycle after the edge that follows reset release, or two edges after a standby pulse. A wrong flag shows at once on `emptyFlag`, but a wrong flag that is never read can hide until a standby resample with the pin low turns it into a wrong source. For that reason the bench resamples after both a flash change and a software flag write. Stale capture logic only shows when the inputs change after capture, so the bench changes every boot input between captures.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

  typedef enum logic [1:0] {
    SRC_MAIN = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_SRAM = 2'd2,
    SRC_EXT  = 2'd3
  } bootSrc_e;

  localparam int NUM_SRC = 4;

  typedef struct packed {
    logic loadOpt;    // option load: refresh the empty flag
    logic latchBoot;  // capture the boot decision
    logic swEnable;   // software writes accepted
  } bootStrb_t;

  function automatic bootSrc_e decideBoot(
    input logic pinSel,
    input logic pin,
    input logic swBoot,
    input logic secBootN,
    input logic blank
  );
    logic effBoot;
    effBoot = pinSel ? pin : ~swBoot;
    if (!effBoot) begin
      decideBoot = (pinSel && blank) ? SRC_SYS : SRC_MAIN;
    end else begin
      decideBoot = secBootN ? SRC_SYS : SRC_SRAM;
    end
  endfunction

endpackage

// File: rtl/boot_sel_ctrl.sv
module boot_sel_ctrl
  import boot_sel_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      standbyExit,
  output bootStrb_t strb,
  output logic      bootValid
);

  typedef enum logic [1:0] {
    ST_LOAD     = 2'd0,
    ST_RUN      = 2'd1,
    ST_RESAMPLE = 2'd2
  } ctrlState_e;

  ctrlState_e state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_LOAD:     stateNext = ST_RUN;
      ST_RUN:      if (standbyExit) stateNext = ST_RESAMPLE;
      ST_RESAMPLE: stateNext = ST_RUN;
      default:     stateNext = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_LOAD;
    else       state <= stateNext;
  end

  always_comb begin
    strb.loadOpt   = (state == ST_LOAD);
    strb.latchBoot = (state == ST_LOAD) || (state == ST_RESAMPLE);
    strb.swEnable  = (state == ST_RUN);
  end

  assign bootValid = (state == ST_RUN);

  // R5: the option load happens once per reset
  p_load_once_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadOpt |=> !strb.loadOpt);

  // R8: a standby pulse while idle leads to a capture on the next cycle
  p_resample_r8: assert property (@(posedge clk) disable iff (!rstN)
    (bootValid && standbyExit) |=> (strb.latchBoot && !bootValid));

endmodule

// File: rtl/boot_sel_dp.sv
module boot_sel_dp
  import boot_sel_pkg::*;
#(
  parameter int FLASH_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  bootStrb_t          strb,
  input  logic               bootPin,
  input  logic               optPinSel,
  input  logic               optSwBoot,
  input  logic               optSecBootN,
  input  logic [FLASH_W-1:0] flashWord0,
  input  logic               emptyWrEn,
  input  logic               emptyWrVal,
  input  logic               remapWrEn,
  input  bootSrc_e           remapWrVal,
  output bootSrc_e           bootSel,
  output bootSrc_e           aliasSel,
  output logic               emptyFlag
);

  localparam logic [FLASH_W-1:0] BLANK_WORD = {FLASH_W{1'b1}};

  logic     flashBlank;
  logic     blankForDecision;
  bootSrc_e decided;

  assign flashBlank = (flashWord0 == BLANK_WORD);
  // during option load the fresh check is used, afterwards the stored flag
  assign blankForDecision = strb.loadOpt ? flashBlank : emptyFlag;
  assign decided = decideBoot(optPinSel, bootPin, optSwBoot, optSecBootN,
                              blankForDecision);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      emptyFlag <= 1'b0;
    end else if (strb.loadOpt) begin
      emptyFlag <= flashBlank;
    end else if (strb.swEnable && emptyWrEn) begin
      emptyFlag <= emptyWrVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bootSel  <= SRC_MAIN;
      aliasSel <= SRC_MAIN;
    end else if (strb.latchBoot) begin
      bootSel  <= decided;
      aliasSel <= decided;
    end else if (strb.swEnable && remapWrEn) begin
      aliasSel <= remapWrVal;
    end
  end

  // R7: the boot selection moves only on a capture strobe
  p_boot_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchBoot |=> $stable(bootSel));

  // R5: the flag moves only at option load or a software write
  p_empty_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadOpt && !(strb.swEnable && emptyWrEn)) |=> $stable(emptyFlag));

  // R9: the alias matches the boot decision right after a capture
  p_alias_follow_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchBoot |=> (aliasSel == bootSel));

  // R3: external flash is never a boot source
  p_no_ext_boot_r3: assert property (@(posedge clk) disable iff (!rstN)
    bootSel != SRC_EXT);

endmodule

// File: rtl/boot_alias_select.sv
module boot_alias_select
  import boot_sel_pkg::*;
#(
  parameter int FLASH_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bootPin,
  input  logic               optPinSel,
  input  logic               optSwBoot,
  input  logic               optSecBootN,
  input  logic [FLASH_W-1:0] flashWord0,
  input  logic               standbyExit,
  input  logic               emptyWrEn,
  input  logic               emptyWrVal,
  input  logic               remapWrEn,
  input  logic [1:0]         remapWrVal,
  output logic [1:0]         bootSel,
  output logic [1:0]         aliasSel,
  output logic [3:0]         aliasOneHot,
  output logic               emptyFlag,
  output logic               bootValid
);

  bootStrb_t strb;
  bootSrc_e  bootSelE;
  bootSrc_e  aliasSelE;

  boot_sel_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .standbyExit(standbyExit),
    .strb       (strb),
    .bootValid  (bootValid)
  );

  boot_sel_dp #(.FLASH_W(FLASH_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .bootPin    (bootPin),
    .optPinSel  (optPinSel),
    .optSwBoot  (optSwBoot),
    .optSecBootN(optSecBootN),
    .flashWord0 (flashWord0),
    .emptyWrEn  (emptyWrEn),
    .emptyWrVal (emptyWrVal),
    .remapWrEn  (remapWrEn),
    .remapWrVal (bootSrc_e'(remapWrVal)),
    .bootSel    (bootSelE),
    .aliasSel   (aliasSelE),
    .emptyFlag  (emptyFlag)
  );

  assign bootSel  = bootSelE;
  assign aliasSel = aliasSelE;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_onehot
    assign aliasOneHot[k] = (aliasSelE == bootSrc_e'(k));
  end

endmodule

// File: tb/boot_alias_select_tb.sv
module boot_alias_select_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bootPin = 1'b0;
  logic        optPinSel = 1'b1;
  logic        optSwBoot = 1'b1;
  logic        optSecBootN = 1'b1;
  logic [31:0] flashWord0 = 32'h2000_1000;
  logic        standbyExit = 1'b0;
  logic        emptyWrEn = 1'b0;
  logic        emptyWrVal = 1'b0;
  logic        remapWrEn = 1'b0;
  logic [1:0]  remapWrVal = 2'd0;
  logic [1:0]  bootSel, aliasSel;
  logic [3:0]  aliasOneHot;
  logic        emptyFlag, bootValid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  string      tagQ[$];
  logic [5:0] expQ[$];  // {valid, empty, alias[1:0], boot[1:0]}
  event       sampleEv;

  always #5 clk = ~clk;

  boot_alias_select u_dut (
    .clk(clk), .rstN(rstN), .bootPin(bootPin), .optPinSel(optPinSel),
    .optSwBoot(optSwBoot), .optSecBootN(optSecBootN), .flashWord0(flashWord0),
    .standbyExit(standbyExit), .emptyWrEn(emptyWrEn), .emptyWrVal(emptyWrVal),
    .remapWrEn(remapWrEn), .remapWrVal(remapWrVal), .bootSel(bootSel),
    .aliasSel(aliasSel), .aliasOneHot(aliasOneHot), .emptyFlag(emptyFlag),
    .bootValid(bootValid)
  );

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(sampleEv);
      while (tagQ.size() > 0) begin
        string      t;
        logic [5:0] e;
        logic [3:0] oh;
        t = tagQ.pop_front();
        e = expQ.pop_front();
        oh = 4'b0001 << e[3:2];
        checks++;
        if (bootSel !== e[1:0] || aliasSel !== e[3:2] || emptyFlag !== e[4] ||
            bootValid !== e[5] || aliasOneHot !== oh) begin
          errors++;
          $display("FAIL %s: got boot=%0d alias=%0d onehot=%b empty=%0d valid=%0d exp boot=%0d alias=%0d onehot=%b empty=%0d valid=%0d",
                   t, bootSel, aliasSel, aliasOneHot, emptyFlag, bootValid,
                   e[1:0], e[3:2], oh, e[4], e[5]);
        end
      end
    end
  end

  task automatic expectNow(input string t, input logic [1:0] b, input logic [1:0] a,
                           input logic em, input logic v);
    tagQ.push_back(t);
    expQ.push_back({v, em, a, b});
    ->sampleEv;
    #1;
  endtask

  task automatic doReset(input logic pinSel, input logic pin, input logic sw,
                         input logic sec, input logic [31:0] w);
    @(negedge clk);
    rstN = 1'b0;
    optPinSel = pinSel; bootPin = pin; optSwBoot = sw; optSecBootN = sec;
    flashWord0 = w;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic standby(input logic pinSel, input logic pin, input logic sw,
                         input logic sec);
    optPinSel = pinSel; bootPin = pin; optSwBoot = sw; optSecBootN = sec;
    standbyExit = 1'b1;
    @(negedge clk);
    standbyExit = 1'b0;
  endtask

  initial begin
    // R10: reset state
    @(negedge clk);
    expectNow("R10 reset state", 2'd0, 2'd0, 1'b0, 1'b0);

    // R1 R2: pin decides, pin low, flash programmed -> main
    doReset(1, 0, 0, 1, 32'h2000_1000);
    expectNow("R1 R2 pin low main", 2'd0, 2'd0, 1'b0, 1'b1);
    // R3: pin high, secondary 0 -> SRAM
    doReset(1, 1, 1, 0, 32'h2000_1000);
    expectNow("R3 pin high sram", 2'd2, 2'd2, 1'b0, 1'b1);
    // R3: pin high, secondary 1 -> system
    doReset(1, 1, 1, 1, 32'h2000_1000);
    expectNow("R3 pin high sys", 2'd1, 2'd1, 1'b0, 1'b1);
    // R1: software value, swBoot=1 -> boot bit 0 -> main (pin ignored)
    doReset(0, 1, 1, 0, 32'h2000_1000);
    expectNow("R1 sw bit main", 2'd0, 2'd0, 1'b0, 1'b1);
    // R1: swBoot=0 -> boot bit 1, secondary 0 -> SRAM (pin low ignored)
    doReset(0, 0, 0, 0, 32'h2000_1000);
    expectNow("R1 sw bit sram", 2'd2, 2'd2, 1'b0, 1'b1);
    // R4 R5: pin low, flash blank -> system, flag set
    doReset(1, 0, 0, 1, 32'hFFFF_FFFF);
    expectNow("R4 R5 blank forces sys", 2'd1, 2'd1, 1'b1, 1'b1);
    // R4: software decides, blank flash ignored
    doReset(0, 0, 1, 1, 32'hFFFF_FFFF);
    expectNow("R4 blank ignored sw", 2'd0, 2'd0, 1'b1, 1'b1);

    // R7 R5: after capture, changing inputs has no effect
    doReset(1, 0, 0, 1, 32'hFFFF_FFFF);
    bootPin = 1'b1; optSecBootN = 1'b0; flashWord0 = 32'h0000_0000;
    @(negedge clk); @(negedge clk);
    expectNow("R7 R5 inputs after capture ignored", 2'd1, 2'd1, 1'b1, 1'b1);

    // R8 R10: standby resample, pin high secondary 0 -> SRAM
    standby(1, 1, 1, 0);
    expectNow("R10 valid low during resample", 2'd1, 2'd1, 1'b1, 1'b0);
    @(negedge clk);
    expectNow("R8 standby resample sram", 2'd2, 2'd2, 1'b1, 1'b1);
    // R8: pin low, flash now programmed but stored flag still 1 -> system
    standby(1, 0, 1, 1);
    @(negedge clk);
    expectNow("R8 resample uses stored flag", 2'd1, 2'd1, 1'b1, 1'b1);

    // R6: software clears flag, resample then boots main
    emptyWrEn = 1'b1; emptyWrVal = 1'b0;
    @(negedge clk);
    emptyWrEn = 1'b0;
    expectNow("R6 sw clears flag", 2'd1, 2'd1, 1'b0, 1'b1);
    standby(1, 0, 1, 1);
    @(negedge clk);
    expectNow("R6 R8 cleared flag gives main", 2'd0, 2'd0, 1'b0, 1'b1);

    // R9: remap to external flash, boot unchanged
    remapWrEn = 1'b1; remapWrVal = 2'd3;
    @(negedge clk);
    remapWrEn = 1'b0;
    expectNow("R9 remap ext", 2'd0, 2'd3, 1'b0, 1'b1);
    remapWrEn = 1'b1; remapWrVal = 2'd2;
    @(negedge clk);
    remapWrEn = 1'b0;
    expectNow("R9 remap sram", 2'd0, 2'd2, 1'b0, 1'b1);
    // R9: resample restores alias to boot decision
    standby(1, 1, 1, 1);
    @(negedge clk);
    expectNow("R9 capture restores alias", 2'd1, 2'd1, 1'b0, 1'b1);
    // R6: software sets flag
    emptyWrEn = 1'b1; emptyWrVal = 1'b1;
    @(negedge clk);
    emptyWrEn = 1'b0;
    expectNow("R6 sw sets flag", 2'd1, 2'd1, 1'b1, 1'b1);

    // R10: back in reset
    @(negedge clk);
    rstN = 1'b0;
    #1;
    expectNow("R10 reset clears", 2'd0, 2'd0, 1'b0, 1'b0);

    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule